// File: doc/BRIEF.md
# Accumulated Result Serial Framer

This block turns a wide accumulated result into a short binary frame for a byte-wide serial transmitter. When the accumulator finishes a summing period, it pulses `load` with the new sum. The framer copies the sum into a private holding register and arms a frame. The frame holds the sum bytes, least significant first, followed by one carriage-return terminator byte.

The surrounding logic offers the framer service slots at a steady rate. In each slot the framer hands the transmitter at most one byte, and only when the transmitter reports that it is empty. A slot that cannot be used leaves the state exactly as it was.

A new `load` always wins. It replaces the held value and restarts the frame at its first byte, whether or not the previous frame had finished.

Top module: `result_frame_sender`

## Requirements
- R1: After reset, `tx_valid` is 0 and `bytes_left` is 0.
- R2: A `load` pulse copies `sum_in` and sets `bytes_left` to the frame length, SUM_W/8+1 (5 by default), one cycle later. No byte is emitted in the cycle that follows a `load`.
- R3: The frame order is fixed. Byte k (k = 0..3) is bits [8k+7:8k] of the held sum, so the least significant byte goes first. The last byte is 13 (carriage return).
- R4: A byte is emitted only for a slot with `slot`=1, `tx_empty`=1, no `load` and `bytes_left` nonzero. It appears as a one-cycle `tx_valid` pulse with `tx_byte` in the cycle after the slot, and `bytes_left` drops by one at the same time.
- R5: A slot with `tx_empty`=0 emits nothing and leaves `bytes_left` unchanged.
- R6: Once `bytes_left` is 0, further slots emit nothing until the next `load`.
- R7: Changes on `sum_in` after a `load` do not alter the bytes of the frame in progress.
- R8: A `load` in the middle of a frame drops the remaining old bytes. The next byte sent is byte 0 of the new value.
- R9: When `load` and a usable slot fall in the same cycle, the load takes effect and no byte is emitted for that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Latch `sum_in` and arm a new frame |
| sum_in | input | SUM_W | Accumulated result to be framed |
| slot | input | 1 | Service slot strobe |
| tx_empty | input | 1 | Transmitter can accept a byte |
| tx_valid | output | 1 | One-cycle strobe: `tx_byte` is to be written |
| tx_byte | output | 8 | Frame byte for the transmitter |
| bytes_left | output | CNT_W | Bytes of the current frame not yet sent |

## Verification
Every result is registered once, so all results are due one clock after the cycle that caused them. This covers the byte pulse after a slot, the reloaded count after a load, and the unchanged count after a refused slot.

The bench drives each stimulus for a single cycle, starting at a falling edge. At the next falling edge it compares `tx_valid`, `tx_byte` and `bytes_left` with a small arithmetic model that is advanced by the same stimulus. So each check samples exactly the cycle in which the output is due, and never the cycle before or after.

The sweep covers many sums, transmitter-busy patterns, loads in the middle of a frame and loads that coincide with a slot. Meanwhile `sum_in` keeps changing between loads.

// File: rtl/result_frame_sender.sv
module result_frame_sender #(
  parameter int          SUM_W     = 32,
  parameter logic [7:0]  TERM_CHAR = 8'd13,
  parameter int          CNT_W     = $clog2(SUM_W / 8 + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SUM_W-1:0] sum_in,
  input  logic             slot,
  input  logic             tx_empty,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic [CNT_W-1:0] bytes_left
);
  localparam int NB    = SUM_W / 8;
  localparam int FRAME = NB + 1;

  logic [SUM_W-1:0] held;
  logic [CNT_W-1:0] pos;
  logic [7:0]       next_byte;
  logic             fire;

  assign pos  = CNT_W'(FRAME) - bytes_left;
  assign fire = slot && tx_empty && !load && (bytes_left != '0);

  always_comb begin
    if (pos == CNT_W'(NB)) next_byte = TERM_CHAR;
    else                   next_byte = 8'(held >> {pos, 3'b000});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= '0;
      bytes_left <= '0;
      tx_valid   <= 1'b0;
      tx_byte    <= '0;
    end else begin
      tx_valid <= fire;
      if (load) begin
        held       <= sum_in;
        bytes_left <= CNT_W'(FRAME);
      end else if (fire) begin
        bytes_left <= bytes_left - CNT_W'(1);
        tx_byte    <= next_byte;
      end
    end
  end
endmodule

module result_frame_sender_chk #(
  parameter int         SUM_W     = 32,
  parameter logic [7:0] TERM_CHAR = 8'd13,
  parameter int         CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             slot,
  input logic             tx_empty,
  input logic             tx_valid,
  input logic [7:0]       tx_byte,
  input logic [CNT_W-1:0] bytes_left
);
  localparam int FRAME = SUM_W / 8 + 1;

  // R2
  load_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bytes_left == CNT_W'(FRAME)) && !tx_valid);

  // R4
  emit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot && tx_empty && !load && bytes_left != '0) |=> !tx_valid);

  // R4
  emit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && tx_empty && !load && bytes_left != '0) |=>
      tx_valid && (bytes_left == $past(bytes_left) - CNT_W'(1)));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !tx_empty && !load) |=> !tx_valid && $stable(bytes_left));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_left == '0 && !load) |=> !tx_valid && bytes_left == '0);

  // R3
  term_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && bytes_left == '0) |-> tx_byte == TERM_CHAR);
endmodule

bind result_frame_sender result_frame_sender_chk #(
  .SUM_W(SUM_W), .TERM_CHAR(TERM_CHAR), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_result_frame_sender.sv
module sim_result_frame_sender;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] sum_in = '0;
  logic        slot = 1'b0;
  logic        tx_empty = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic [2:0]  bytes_left;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_held = '0;
  int          m_left = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  result_frame_sender u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .sum_in(sum_in), .slot(slot),
    .tx_empty(tx_empty), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .bytes_left(bytes_left)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit ld, input logic [31:0] v, input bit sl,
                      input bit em, input logic [31:0] junk, input string tag);
    bit          ev;
    logic [7:0]  eb;
    int          idx;
    ev = 0; eb = '0;
    load = ld; sum_in = ld ? v : junk; slot = sl; tx_empty = em;
    if (ld) begin
      m_held = v; m_left = 5;
    end else if (sl && em && m_left != 0) begin
      idx = 5 - m_left;
      ev  = 1;
      eb  = (idx == 4) ? 8'd13 : 8'((m_held >> (8 * idx)) & 32'hFF);
      m_left--;
    end
    @(negedge clk);
    load = 0; slot = 0; sum_in = ~junk;
    chk({tag, " tx_valid"}, 32'(tx_valid), 32'(ev));
    chk({tag, " bytes_left"}, 32'(bytes_left), 32'(m_left));
    if (ev) chk({tag, " tx_byte"}, 32'(tx_byte), 32'(eb));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
    chk("R1 bytes_left", 32'(bytes_left), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 1, 1, 32'h1234, "R6 idle");

    for (int s = 0; s < 40; s++) begin
      logic [31:0] val;
      val = (32'h9E3779B9 * (s + 1)) ^ (s << 5);
      step(1, val, 0, 0, ~val, "R2 load");
      for (int k = 0; k < 9; k++) begin
        bit em;
        em = ((s * 5 + k * 3) % 4) != 0;
        step(0, 0, 1, em, val + k, em ? "R3 R4 R7" : "R5 busy");
      end
      for (int k = 0; k < 6; k++) step(0, 0, 1, 1, val ^ k, "R3 R6 drain");
    end

    for (int s = 0; s < 24; s++) begin
      logic [31:0] a, b;
      a = 32'hA5000000 + s * 32'h01010101;
      b = ~a;
      step(1, a, 0, 0, 0, "R2 load");
      for (int k = 0; k < s % 5; k++) step(0, 0, 1, 1, k, "R3 pre");
      step(1, b, (s % 2) == 1, 1, 0, "R8 R9 reload");
      for (int k = 0; k < 6; k++) step(0, 0, 1, 1, a ^ k, "R8 restart");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule